// File: doc/BRIEF.md
# Burst Bus Master with Back-off Resume

This block is the processor-side master of a synchronous burst bus. It takes one line command at a time from the core side: a line read (fill) or a line write (copy-back) of `BEATS` words of `DATA_W` bits. It requests the bus, waits for grant, then issues an address strobe with the address of the current beat and a count of the beats still owed. After that it moves one word per ready strobe, in rising address order.

A back-off input can take the bus away at any point. The master stops driving address, data and control on the clock after back-off is sampled, and it drops its request. It keeps the beat counter and the line storage. When back-off goes low it requests the bus again and strobes the address of the first beat that has not completed, so no beat is transferred twice and none is skipped. A ready strobe that coincides with back-off does not count. A lock indication for the arbiter is held from acceptance of a locked command until the command completes, including while the master is backed off.

Top module: `burst_resume_master`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `bus_req`, `bus_drive`, `bus_ads`, `bus_lock` and `rsp_done` are all 0.
- R2: One clock after a command is accepted (`cmd_valid` and `cmd_ready` high at an edge), `bus_req` is 1. `bus_ads` is asserted only in the clock after one in which the master requested the bus without driving it, `bus_gnt` was 1 and `bus_backoff` was 0.
- R3: `bus_ads` lasts exactly one clock, with `bus_drive` high. The low log2(BEATS*DATA_W/8) bits of `cmd_addr` are ignored. The strobed address is the line base plus beat index times DATA_W/8.
- R4: The beat index advances only on an edge where `bus_rdy` is 1, `bus_backoff` is 0 and the master is in its data phase (driving, no strobe). On a read, `bus_rdata` is stored as word k of `rsp_rline` (bits k*DATA_W upward), where k is the current beat index.
- R5: If `bus_backoff` is 1 at an edge while `bus_req` or `bus_drive` is 1, then after that edge `bus_drive`, `bus_req` and `bus_ads` are 0, whatever phase was in progress.
- R6: A `bus_rdy` sampled in the same clock as `bus_backoff` is ignored: that beat stays incomplete and is requested again after resume.
- R7: After `bus_backoff` falls, the master requests the bus again. It strobes the address of the first incomplete beat, with `bus_remain` = BEATS minus the number of completed beats.
- R8: During the data phase of a write, `bus_wdata` holds word k of `cmd_wline` for the current beat k, and `bus_write` is 1 while driving.
- R9: For a command accepted with `cmd_lock` = 1, `bus_lock` stays 1 from the clock after acceptance through the `rsp_done` clock, across any back-off. For an unlocked command it stays 0.
- R10: `rsp_done` is a single-clock pulse in the clock after the last beat completes. Each burst completes exactly BEATS beats. In the following clock `cmd_ready` is 1 and `bus_lock` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Line command offered |
| cmd_ready | output | 1 | Master idle, command can be accepted |
| cmd_write | input | 1 | 1 = line write, 0 = line read |
| cmd_lock | input | 1 | Command belongs to a locked sequence |
| cmd_addr | input | ADDR_W | Line address (offset bits ignored) |
| cmd_wline | input | DATA_W*BEATS | Line to write, word 0 in the low bits |
| rsp_done | output | 1 | Command complete pulse |
| rsp_rline | output | DATA_W*BEATS | Line read, word 0 in the low bits |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_backoff | input | 1 | Forces the master off the bus |
| bus_ads | output | 1 | Address strobe |
| bus_drive | output | 1 | Output enable for address, data and control |
| bus_write | output | 1 | Cycle direction, 1 = write |
| bus_lock | output | 1 | Locked sequence flag to arbiter |
| bus_addr | output | ADDR_W | Beat address |
| bus_remain | output | $clog2(BEATS+1) | Beats still owed, valid with the strobe |
| bus_wdata | output | DATA_W | Write data of current beat |
| bus_rdata | input | DATA_W | Read data |
| bus_rdy | input | 1 | Per-beat ready |

## Verification
The beat counter and the line store are the only state that survives a back-off. A corrupted counter shows at the very next address strobe as a wrong resume address or remaining count. It also shows at completion as a beat count that differs from BEATS. A wrong slot index shows on the write data bus in the same clock as the ready strobe, or in the read line at `rsp_done`. A sequencer that reacts late to back-off shows one clock after the back-off sample as a still-asserted drive or request. Back-off is placed at the request phase, at the strobe, and at every beat of both a read and a write, with ready held high in the same clock.

// File: rtl/brm_pkg.sv
package brm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_ADDR,
      ST_DATA,
      ST_BOFF,
      ST_DONE
   } brm_state_e;

endpackage

// File: rtl/brm_sequencer.sv
module brm_sequencer
   import brm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       bus_gnt,
   input  logic       backoff,
   input  logic       bus_rdy,
   input  logic       last_beat,
   output brm_state_e state,
   output logic       beat_ok
);

   brm_state_e state_q, state_d;

   always_comb beat_ok = (state_q == ST_DATA) && bus_rdy && !backoff;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start) state_d = ST_REQ;
         ST_REQ: begin
            if (backoff)      state_d = ST_BOFF;
            else if (bus_gnt) state_d = ST_ADDR;
         end
         ST_ADDR: state_d = backoff ? ST_BOFF : ST_DATA;
         ST_DATA: begin
            if (backoff)                 state_d = ST_BOFF;
            else if (beat_ok && last_beat) state_d = ST_DONE;
         end
         ST_BOFF: if (!backoff) state_d = ST_REQ;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state = state_q;

endmodule

// File: rtl/brm_beat_tracker.sv
module brm_beat_tracker #(
   parameter int BEATS  = 4,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(BEATS),
   localparam int CNT_W = $clog2(BEATS + 1),
   localparam int OFF_W = $clog2(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              advance,
   input  logic [ADDR_W-1:0] base_addr,
   output logic [IDX_W-1:0]  beat_idx,
   output logic              last_beat,
   output logic [ADDR_W-1:0] beat_addr,
   output logic [CNT_W-1:0]  remain
);

   logic [IDX_W-1:0] beat_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       beat_q <= '0;
      else if (clear)   beat_q <= '0;
      else if (advance) beat_q <= beat_q + 1'b1;
   end

   always_comb begin
      beat_idx  = beat_q;
      last_beat = (beat_q == IDX_W'(BEATS - 1));
      beat_addr = base_addr + (ADDR_W'(beat_q) << OFF_W);
      remain    = CNT_W'(BEATS) - CNT_W'(beat_q);
   end

endmodule

// File: rtl/brm_line_buffer.sv
module brm_line_buffer #(
   parameter int BEATS  = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W  = $clog2(BEATS),
   localparam int LINE_W = DATA_W * BEATS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LINE_W-1:0] load_line,
   input  logic              capture,
   input  logic [IDX_W-1:0]  beat_idx,
   input  logic [DATA_W-1:0] cap_word,
   output logic [DATA_W-1:0] cur_word,
   output logic [LINE_W-1:0] line
);

   logic [DATA_W-1:0] slot_q [BEATS];

   for (genvar g = 0; g < BEATS; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[g] <= '0;
         else if (load)
            slot_q[g] <= load_line[g*DATA_W +: DATA_W];
         else if (capture && (beat_idx == IDX_W'(g)))
            slot_q[g] <= cap_word;
      end
      assign line[g*DATA_W +: DATA_W] = slot_q[g];
   end

   assign cur_word = slot_q[beat_idx];

endmodule

// File: rtl/burst_resume_master.sv
module burst_resume_master
   import brm_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 32,
   parameter int BEATS     = 4,
   parameter bit ADDR_HOLD = 1'b1,
   localparam int LINE_W   = DATA_W * BEATS,
   localparam int IDX_W    = $clog2(BEATS),
   localparam int CNT_W    = $clog2(BEATS + 1),
   localparam int OFF_W    = $clog2(DATA_W / 8),
   localparam int LINE_OFF = OFF_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic              cmd_lock,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LINE_W-1:0] cmd_wline,
   output logic              rsp_done,
   output logic [LINE_W-1:0] rsp_rline,
   output logic              bus_req,
   input  logic              bus_gnt,
   input  logic              bus_backoff,
   output logic              bus_ads,
   output logic              bus_drive,
   output logic              bus_write,
   output logic              bus_lock,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [CNT_W-1:0]  bus_remain,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_rdy
);

   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("BEATS must be a power of two of at least 2");
   end
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (ADDR_W <= LINE_OFF) begin : g_bad_addr
      $error("ADDR_W too small for one line");
   end

   brm_state_e        st;
   logic              start, beat_ok, last_beat;
   logic              wr_q, lk_q;
   logic [ADDR_W-1:0] base_q, beat_addr;
   logic [IDX_W-1:0]  beat_idx;
   logic [CNT_W-1:0]  remain;
   logic [DATA_W-1:0] cur_word;

   assign cmd_ready = (st == ST_IDLE);
   assign start     = cmd_valid && cmd_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q   <= 1'b0;
         lk_q   <= 1'b0;
         base_q <= '0;
      end else if (start) begin
         wr_q   <= cmd_write;
         lk_q   <= cmd_lock;
         base_q <= {cmd_addr[ADDR_W-1:LINE_OFF], {LINE_OFF{1'b0}}};
      end
   end

   brm_sequencer u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .bus_gnt   (bus_gnt),
      .backoff   (bus_backoff),
      .bus_rdy   (bus_rdy),
      .last_beat (last_beat),
      .state     (st),
      .beat_ok   (beat_ok)
   );

   brm_beat_tracker #(
      .BEATS  (BEATS),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start),
      .advance   (beat_ok),
      .base_addr (base_q),
      .beat_idx  (beat_idx),
      .last_beat (last_beat),
      .beat_addr (beat_addr),
      .remain    (remain)
   );

   brm_line_buffer #(
      .BEATS  (BEATS),
      .DATA_W (DATA_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .load_line (cmd_wline),
      .capture   (beat_ok && !wr_q),
      .beat_idx  (beat_idx),
      .cap_word  (bus_rdata),
      .cur_word  (cur_word),
      .line      (rsp_rline)
   );

   assign bus_drive  = (st == ST_ADDR) || (st == ST_DATA);
   assign bus_ads    = (st == ST_ADDR);
   assign bus_req    = (st == ST_REQ) || bus_drive;
   assign bus_write  = bus_drive && wr_q;
   assign bus_lock   = lk_q && (st != ST_IDLE);
   assign bus_remain = bus_ads ? remain : '0;
   assign bus_wdata  = bus_write ? cur_word : '0;
   assign rsp_done   = (st == ST_DONE);

   if (ADDR_HOLD) begin : g_addr_hold
      assign bus_addr = bus_drive ? beat_addr : '0;
   end else begin : g_addr_strobe
      assign bus_addr = bus_ads ? beat_addr : '0;
   end

endmodule

// File: rtl/brm_checker.sv
module brm_checker #(
   parameter int IDX_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_req,
   input logic             bus_gnt,
   input logic             bus_backoff,
   input logic             bus_ads,
   input logic             bus_drive,
   input logic             bus_lock,
   input logic             bus_rdy,
   input logic             rsp_done,
   input logic             cmd_ready,
   input logic [IDX_W-1:0] beat_idx
);

   assert_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_drive || bus_req) && bus_backoff |=> !bus_drive && !bus_req && !bus_ads);

   assert_ads_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ads |-> $past(bus_req && !bus_drive && bus_gnt && !bus_backoff));

   assert_ads_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ads |=> !bus_ads);

   assert_ads_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ads |-> bus_drive);

   assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_lock && !rsp_done |=> bus_lock);

   assert_beat_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(beat_idx) |-> $past(bus_rdy && !bus_backoff && bus_drive && !bus_ads));

   assert_beat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_backoff |=> $stable(beat_idx));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done && cmd_ready && !bus_lock);

endmodule

bind burst_resume_master brm_checker #(.IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_req     (bus_req),
   .bus_gnt     (bus_gnt),
   .bus_backoff (bus_backoff),
   .bus_ads     (bus_ads),
   .bus_drive   (bus_drive),
   .bus_lock    (bus_lock),
   .bus_rdy     (bus_rdy),
   .rsp_done    (rsp_done),
   .cmd_ready   (cmd_ready),
   .beat_idx    (beat_idx)
);

// File: tb/tb_burst_resume_master.sv
`timescale 1ns/1ps
module tb_burst_resume_master;

   localparam int DW = 32;
   localparam int AW = 32;
   localparam int NB = 4;
   localparam int LW = DW * NB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0, cmd_write = 1'b0, cmd_lock = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [LW-1:0] cmd_wline = '0;
   logic          cmd_ready, rsp_done;
   logic [LW-1:0] rsp_rline;
   logic          bus_req, bus_ads, bus_drive, bus_write, bus_lock;
   logic          bus_gnt = 1'b0, bus_backoff = 1'b0, bus_rdy = 1'b0;
   logic [AW-1:0] bus_addr;
   logic [2:0]    bus_remain;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata = '0;

   int n_checks = 0;
   int n_fails  = 0;
   int n_cycles = 0;

   always #4 clk = ~clk;

   burst_resume_master dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
      .cmd_lock(cmd_lock), .cmd_addr(cmd_addr), .cmd_wline(cmd_wline),
      .rsp_done(rsp_done), .rsp_rline(rsp_rline),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_backoff(bus_backoff),
      .bus_ads(bus_ads), .bus_drive(bus_drive), .bus_write(bus_write),
      .bus_lock(bus_lock), .bus_addr(bus_addr), .bus_remain(bus_remain),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
   );

   function automatic logic [DW-1:0] rd_word(input logic [AW-1:0] base, input int k);
      return base ^ (32'h1111_1111 * (k + 1)) ^ 32'hA5A5_0000;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [LW-1:0] act,
                        input logic [LW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      n_cycles++;
      if (n_cycles > 150000) begin
         n_checks++;
         n_fails++;
         $display("FAIL R10 watchdog actual=%0d expected<150000", n_cycles);
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end

   // inj: 0..3 = back-off on that data beat, 4 = during request, 5 = on strobe, -1 = none
   task automatic run_txn(input bit wr, input bit lk, input int inj, input bit rnd);
      logic [AW-1:0] base;
      logic [LW-1:0] wl, exp_rl;
      int  got, hold, cyc;
      bit  injected, prev_float, prev_grant, saw_done, data, boff, rdy, gnt;
      base = $urandom() & 32'hFFFF_FFF0;
      wl   = {$urandom(), $urandom(), $urandom(), $urandom()};
      for (int i = 0; i < NB; i++) exp_rl[i*DW +: DW] = rd_word(base, i);
      check(cmd_ready == 1'b1, "R10 ready before command", LW'(cmd_ready), 1);
      cmd_valid = 1'b1; cmd_write = wr; cmd_lock = lk;
      cmd_addr  = base | AW'($urandom() & 15);
      cmd_wline = wl;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_addr = '0;
      check(bus_req == 1'b1, "R2 request after accept", LW'(bus_req), 1);
      got = 0; hold = 0; cyc = 0;
      injected = 0; prev_float = 0; prev_grant = 0; saw_done = 0;
      while (!saw_done && cyc < 400) begin
         if (prev_float)
            check(!bus_drive && !bus_req && !bus_ads, "R5 float after back-off",
                  LW'({bus_drive, bus_req, bus_ads}), 0);
         if (bus_ads) begin
            check(prev_grant, "R2 strobe after grant", LW'(prev_grant), 1);
            check(bus_addr == base + AW'(got * 4), "R3 R7 strobe address",
                  LW'(bus_addr), LW'(base + AW'(got * 4)));
            check(bus_remain == 3'(NB - got), "R7 remaining count",
                  LW'(bus_remain), LW'(NB - got));
            check(bus_write == wr, "R8 direction", LW'(bus_write), LW'(wr));
         end
         check(bus_lock == lk, "R9 lock level", LW'(bus_lock), LW'(lk));
         if (rsp_done) begin
            saw_done = 1;
         end else begin
            data = bus_drive && !bus_ads;
            boff = 0; rdy = 0;
            if (hold > 0) begin
               boff = 1; hold--;
            end else if (!injected && ((inj >= 0 && inj < 4 && data && got == inj) ||
                                       (inj == 4 && bus_req && !bus_drive) ||
                                       (inj == 5 && bus_ads))) begin
               boff = 1; injected = 1; hold = 2;
            end else if (rnd && ($urandom() % 12 == 0)) begin
               boff = 1; hold = int'($urandom() % 3);
            end
            if (data) rdy = boff ? 1'b1 : (rnd ? ($urandom() % 4 != 0) : 1'b1);
            gnt = rnd ? (bus_req && ($urandom() % 3 != 0)) : bus_req;
            bus_rdata = 32'hDEAD_BEEF;
            if (data && rdy && !boff) begin
               if (wr)
                  check(bus_wdata == wl[got*DW +: DW], "R8 write word",
                        LW'(bus_wdata), LW'(wl[got*DW +: DW]));
               bus_rdata = rd_word(base, got);
               got++;
            end
            prev_float = boff && (bus_drive || bus_req);
            prev_grant = bus_req && !bus_drive && gnt && !boff;
            bus_backoff = boff; bus_rdy = rdy; bus_gnt = gnt;
            @(negedge clk);
            cyc++;
         end
      end
      bus_backoff = 0; bus_rdy = 0; bus_gnt = 0;
      check(saw_done, "R10 completion seen", LW'(saw_done), 1);
      check(got == NB, "R10 R6 beats transferred once", LW'(got), LW'(NB));
      if (!wr) check(rsp_rline == exp_rl, "R4 read line", rsp_rline, exp_rl);
      @(negedge clk);
      check(cmd_ready && !bus_lock && !rsp_done, "R10 R9 return to idle",
            LW'({cmd_ready, bus_lock, rsp_done}), LW'(3'b100));
   endtask

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_ready && !bus_req && !bus_drive && !bus_ads && !bus_lock && !rsp_done,
            "R1 reset state",
            LW'({cmd_ready, bus_req, bus_drive, bus_ads, bus_lock, rsp_done}),
            LW'(6'b100000));
      for (int w = 0; w < 2; w++)
         for (int p = 0; p < 6; p++)
            run_txn(w[0], p[0], p, 1'b0);
      run_txn(1'b0, 1'b1, -1, 1'b0);
      run_txn(1'b1, 1'b0, -1, 1'b0);
      for (int r = 0; r < 60; r++)
         run_txn(1'($urandom()), 1'($urandom()), -1, 1'b1);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

endmodule